// File: doc/BRIEF.md
# Comma-Aligned Deserializer with Byte Clocks

This block sits right after clock recovery on a serial receive lane. It runs on the recovered bit clock and takes in one data bit per cycle. It gathers the bits into 10-bit characters and presents each character on a parallel output. It also drives two complementary byte clocks that run at half the character rate, so a new character appears on every rising edge of one of the two clocks. Characters whose boundary falls on the odd clock's rising edge alternate with characters on the even clock's rising edge.

The block watches the incoming stream for the positive-disparity comma. When a comma completes anywhere other than the expected ordered-set position, the block moves its character and ordered-set framing to match. It does this by holding the byte clocks at their current level for longer, so no phase is ever cut short. After the move, the next comma is presented on a rising edge of the odd byte clock. A sync flag shows that a comma has arrived at the expected position.

While the signal-valid input is low, the parallel output reads all ones and the sync flag drops.

Top module: `desa_deser`

## Requirements
- R1: The output is 10 bits wide, and the first-received bit of a character sits in bit 9. After reset, framing starts at bit 0 of the stream, and the first character is loaded at the 20th bit clock with stream bits 10 to 19.
- R2: A comma is a 10-bit window whose first seven received bits are 0011111, with the last three bits of any value. The pattern 1100000xxx has no effect on the framing, the byte clocks or the sync flag.
- R3: If a comma completes away from the ordered-set position, the framing moves so that a comma arriving 20 bit clocks later is loaded on a rising edge of `bclk_odd` and appears on `rx_word`.
- R4: No high or low phase of the byte clocks is shorter than 10 bit clocks. A realignment only lengthens the current phase.
- R5: Once aligned, `bclk_odd` runs 10 bit clocks high and 10 low, and `bclk_even` is always its complement. Each character load coincides with a toggle of the byte clocks.
- R6: Reset is synchronous and active low. After reset, `rx_word` is all ones, `bclk_odd` is 0, `bclk_even` is 1 and `sync` is 0.
- R7: While `sig_ok` is 0, `rx_word` reads 1111111111 in the same cycle. When `sig_ok` returns to 1, the last loaded character shows again, and later characters pass through unchanged.
- R8: `sync` goes to 1 after the clock edge at which a comma completes at the ordered-set position. It goes to 0 after a realignment, and after any edge at which `sig_ok` is 0.
- R9: A comma that completes at the ordered-set position causes no realignment. It is loaded on a rising edge of `bclk_odd`, and the clocks keep their timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data bit, one per clock |
| sig_ok | input | 1 | Line signal valid; low forces the output to all ones |
| rx_word | output | 10 | Aligned parallel character, first bit received in bit 9 |
| bclk_odd | output | 1 | Byte clock; its rising edge carries comma characters |
| bclk_even | output | 1 | Complement of `bclk_odd` |
| sync | output | 1 | A comma has been seen at the current framing |

## Verification
A wrong frame position shows at the ports within one ordered set of 20 bit clocks. The comma then lands on a falling edge of `bclk_odd`, or not on a character boundary, and `sync` stays low. A wrong clock level after a realignment shows up as a phase shorter than 10 bit clocks, or as characters and comma parity landing on the wrong clock. The stimulus places the first comma at several offsets, with the clock both high and low, so these cases are reached. A squelch fault shows in the same cycle as all-ones data, or one edge later as `sync` failing to drop.

// File: rtl/desa_pkg.sv
// Shared constants for the comma-aligned deserializer.
// Assumes: characters are 10 bits and the comma prefix is 7 bits long.
package desa_pkg;
    localparam int unsigned CHAR_BITS = 10;
    localparam int unsigned MARK_BITS = 7;
    localparam logic [MARK_BITS-1:0] MARK_PATTERN = 7'b0011111;
endpackage

// File: rtl/desa_window.sv
// Sliding character window and comma matcher.
// Holds the last CHAR_W-1 bits and appends the current bit, so the window
// is the character that would end at this clock. The oldest bit is the MSB.
// Assumes: one serial bit per clock and no gaps in the stream.
module desa_window
    import desa_pkg::*;
#(
    parameter int unsigned CHAR_W   = CHAR_BITS,
    parameter int unsigned MARK_W   = MARK_BITS,
    parameter logic [MARK_W-1:0] MARK_PAT = MARK_PATTERN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    output logic [CHAR_W-1:0] cand,
    output logic              mark_hit
);
    logic [CHAR_W-2:0] hist;

    // The window is the history bits followed by the bit arriving now.
    assign cand = {hist, bit_in};

    // The comma prefix sits in the oldest bits; the newest bits are don't-care.
    assign mark_hit = (cand[CHAR_W-1 -: MARK_W] == MARK_PAT);

    // Shift history: drop the oldest bit each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= cand[CHAR_W-2:0];
    end
endmodule

// File: rtl/desa_framer.sv
// Ordered-set position counter, realignment and sync tracking.
// One ordered set is two characters. A comma should finish at the last
// position of the set. A comma finishing anywhere else restarts the count,
// and that cycle loads nothing. Loads depend on the clock level, so a load
// always means a real edge: a fall at mid-set needs the clock high, and a
// rise at set end needs it low. A load whose level does not match is skipped,
// which lengthens the phase.
// Assumes: commas never come in adjacent characters.
module desa_framer
    import desa_pkg::*;
#(
    parameter int unsigned CHAR_W = CHAR_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mark_hit,
    input  logic sig_ok,
    input  logic clk_level,
    output logic load,
    output logic in_sync
);
    localparam int unsigned FRAME = 2 * CHAR_W;
    localparam int unsigned CW    = $clog2(FRAME);
    localparam logic [CW-1:0] POS_LAST = CW'(FRAME - 1);
    localparam logic [CW-1:0] POS_MID  = CW'(CHAR_W - 1);

    logic [CW-1:0] pos;
    logic          at_end;
    logic          relock;

    assign at_end = (pos == POS_LAST);
    assign relock = mark_hit && !at_end;

    // Load a character only on an edge that matches the current clock level.
    assign load = !relock &&
                  (((pos == POS_MID) && clk_level) || (at_end && !clk_level));

    // Count position in the ordered set; a misplaced comma restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)           pos <= '0;
        else if (relock || at_end) pos <= '0;
        else                  pos <= pos + 1'b1;
    end

    // Sync flag: set by a well-placed comma, cleared by squelch or relock.
    always_ff @(posedge clk) begin
        if (!rst_n)                in_sync <= 1'b0;
        else if (!sig_ok)          in_sync <= 1'b0;
        else if (relock)           in_sync <= 1'b0;
        else if (mark_hit && at_end) in_sync <= 1'b1;
    end
endmodule

// File: rtl/desa_bclk.sv
// Byte clock pair. Both clocks toggle on each character load, with the even
// clock driven from its own flop as the complement. A run counter tracks
// how long the current phase has lasted, so the minimum phase length can
// be checked here.
// Assumes: loads come from desa_framer, which never places two within a character.
module desa_bclk
    import desa_pkg::*;
#(
    parameter int unsigned CHAR_W = CHAR_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic odd_q,
    output logic even_q
);
    localparam int unsigned RUN_MAX = 4 * CHAR_W;
    localparam int unsigned RW      = $clog2(RUN_MAX + 1);

    logic [RW-1:0] run;

    // Toggle the pair on each load; reset leaves the odd clock low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odd_q  <= 1'b0;
            even_q <= 1'b1;
        end else if (load) begin
            odd_q  <= ~odd_q;
            even_q <= odd_q;
        end
    end

    // Count the bit clocks spent in the current phase, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                 run <= '0;
        else if (load)              run <= '0;
        else if (run != RW'(RUN_MAX)) run <= run + 1'b1;
    end

    AST_MIN_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (run >= RW'(CHAR_W - 1)));                       // R4
    AST_CLK_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
        odd_q != even_q);                                         // R5
endmodule

// File: rtl/desa_deser.sv
// Top level: window, framer, byte clocks and the output register.
// The character register is written only on load strobes. The squelch
// forcing comes after the register, so it acts in the same cycle and the
// stored character survives a short loss of signal.
// Assumes: sig_ok is already synchronous to clk.
module desa_deser
    import desa_pkg::*;
#(
    parameter int unsigned CHAR_W = CHAR_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_in,
    input  logic              sig_ok,
    output logic [CHAR_W-1:0] rx_word,
    output logic              bclk_odd,
    output logic              bclk_even,
    output logic              sync
);
    logic [CHAR_W-1:0] cand;
    logic [CHAR_W-1:0] word_q;
    logic              mark_hit;
    logic              load;

    desa_window #(.CHAR_W(CHAR_W)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_in   (ser_in),
        .cand     (cand),
        .mark_hit (mark_hit)
    );

    desa_framer #(.CHAR_W(CHAR_W)) u_framer (
        .clk       (clk),
        .rst_n     (rst_n),
        .mark_hit  (mark_hit),
        .sig_ok    (sig_ok),
        .clk_level (bclk_odd),
        .load      (load),
        .in_sync   (sync)
    );

    desa_bclk #(.CHAR_W(CHAR_W)) u_bclk (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .odd_q  (bclk_odd),
        .even_q (bclk_even)
    );

    // Capture the finished character on each load; reset reads all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)    word_q <= '1;
        else if (load) word_q <= cand;
    end

    // Squelch each output bit high while the line signal is invalid.
    for (genvar i = 0; i < CHAR_W; i++) begin : g_squelch
        assign rx_word[i] = word_q[i] | ~sig_ok;
    end

    AST_SYNC_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync) |-> $rose(bclk_odd));                         // R3
    AST_SQUELCH_DROPS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        !sig_ok |=> !sync);                                       // R8
endmodule

// File: tb/sim_desa_deser.sv
// Self-checking bench for desa_deser.
module sim_desa_deser;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_in = 1'b0;
    logic       sig_ok = 1'b1;
    logic [9:0] rx_word;
    logic       bclk_odd;
    logic       bclk_even;
    logic       sync;

    int errors = 0;
    int checks = 0;
    int ei = 0;

    localparam logic [9:0] DW = 10'b1001010110;
    localparam logic [9:0] KN = 10'b1100000101;
    // Table entry: offset[15:11], comma word[10:1], already aligned[0]
    localparam logic [15:0] SCEN [5] = '{
        {5'd0,  10'b0011111010, 1'b0},
        {5'd3,  10'b0011111000, 1'b0},
        {5'd10, 10'b0011111010, 1'b1},
        {5'd17, 10'b0011111101, 1'b0},
        {5'd9,  10'b0011111010, 1'b0}
    };

    always #4 clk = ~clk;

    desa_deser u0 (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .sig_ok(sig_ok),
        .rx_word(rx_word), .bclk_odd(bclk_odd), .bclk_even(bclk_even), .sync(sync)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic push_bit(input logic b);
        @(negedge clk);
        ser_in = b;
        @(posedge clk);
        #2;
        ei++;
    endtask

    task automatic push_char(input logic [9:0] w);
        for (int k = 9; k >= 0; k--) push_bit(w[k]);
    endtask

    // Push a character, checking the odd clock level each bit and the load at the end.
    task automatic push_char_chk(input logic [9:0] w, input logic lvl_mid,
                                 input logic lvl_end, input string req);
        for (int k = 9; k >= 0; k--) begin
            push_bit(w[k]);
            if (k > 0) begin
                chk(bclk_odd == lvl_mid, req, "odd level mid", int'(bclk_odd), int'(lvl_mid));
            end else begin
                chk(bclk_odd == lvl_end, req, "odd level end", int'(bclk_odd), int'(lvl_end));
                chk(rx_word == w, req, "word at edge", int'(rx_word), int'(w));
            end
            chk(bclk_even == ~bclk_odd, req, "even complement", int'(bclk_even), int'(~bclk_odd));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        sig_ok = 1'b1;
        ser_in = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1'b1;
        ei = 0;
    endtask

    // R4: phase length monitor on the odd byte clock
    int  run_len = 0;
    logic last_lvl = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            run_len = 0;
            last_lvl = bclk_odd;
        end else if (bclk_odd != last_lvl) begin
            chk(run_len >= 10, "R4", "phase length", run_len, 10);
            run_len = 1;
            last_lvl = bclk_odd;
        end else begin
            run_len++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R1..: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [42:0] stream;
        logic [9:0]  kw;
        logic        al;
        int          off;

        // R6: reset state
        do_reset();
        chk(rx_word == 10'h3FF, "R6", "reset word", int'(rx_word), 'h3FF);
        chk(bclk_odd == 1'b0, "R6", "reset odd", int'(bclk_odd), 0);
        chk(bclk_even == 1'b1, "R6", "reset even", int'(bclk_even), 1);
        chk(sync == 1'b0, "R6", "reset sync", int'(sync), 0);

        // Table walk: first comma at several offsets
        for (int s = 0; s < 5; s++) begin
            off = int'(SCEN[s][15:11]);
            kw  = SCEN[s][10:1];
            al  = SCEN[s][0];
            do_reset();
            repeat (off) push_bit(1'b0);
            push_char(kw);
            if (al) begin
                chk(sync == 1'b1, "R9", "aligned sync", int'(sync), 1);
                chk(bclk_odd == 1'b1, "R9", "aligned rise", int'(bclk_odd), 1);
                chk(rx_word == kw, "R9", "aligned word", int'(rx_word), int'(kw));
            end else begin
                chk(sync == 1'b0, "R8", "sync after relock", int'(sync), 0);
            end
            push_char(DW);
            push_char(kw);
            chk(bclk_odd == 1'b1, "R3", "second comma on odd rise", int'(bclk_odd), 1);
            chk(rx_word == kw, "R3", "second comma word", int'(rx_word), int'(kw));
            chk(sync == 1'b1, "R8", "sync after aligned comma", int'(sync), 1);
            push_char_chk(DW, 1'b1, 1'b0, "R5");
            push_char_chk(kw, 1'b0, 1'b1, "R5");
        end

        // R2 / R1: negative-disparity comma ignored, framing from reset
        do_reset();
        stream = {3'b000, KN, DW, KN, DW};
        for (int i = 0; i < 43; i++) begin
            push_bit(stream[42 - i]);
            if (i == 19) begin
                chk(bclk_odd == 1'b1, "R2", "odd at 19", int'(bclk_odd), 1);
                chk(rx_word == 10'b1011001010, "R1", "first word", int'(rx_word), 'h2CA);
            end
            if (i == 29) chk(bclk_odd == 1'b0, "R2", "odd at 29", int'(bclk_odd), 0);
            if (i == 39) chk(bclk_odd == 1'b1, "R2", "odd at 39", int'(bclk_odd), 1);
        end
        chk(sync == 1'b0, "R2", "sync stays low", int'(sync), 0);

        // R7 / R8: squelch while synced
        do_reset();
        repeat (3) push_bit(1'b0);
        push_char(10'b0011111010);
        push_char(DW);
        push_char(10'b0011111010);
        chk(sync == 1'b1, "R8", "sync before squelch", int'(sync), 1);
        push_char(DW);
        sig_ok = 1'b0;
        #1;
        chk(rx_word == 10'h3FF, "R7", "squelch same cycle", int'(rx_word), 'h3FF);
        push_bit(1'b0);
        chk(rx_word == 10'h3FF, "R7", "squelch word", int'(rx_word), 'h3FF);
        chk(sync == 1'b0, "R8", "squelch clears sync", int'(sync), 0);
        sig_ok = 1'b1;
        #1;
        chk(rx_word == DW, "R7", "word restored", int'(rx_word), int'(DW));
        repeat (9) push_bit(1'b0);
        chk(rx_word == 10'h000, "R7", "data passes", int'(rx_word), 0);
        push_char(DW);
        push_char(10'b0011111010);
        chk(rx_word == 10'b0011111010, "R8", "comma after squelch", int'(rx_word), 'h0FA);
        chk(sync == 1'b1, "R8", "sync regained", int'(sync), 1);
        chk(bclk_odd == 1'b1, "R3", "comma on odd rise", int'(bclk_odd), 1);

        finish_run();
    end
endmodule